// File: doc/BRIEF.md
# Pin Change Wake and Interrupt Unit

The unit watches up to 21 asynchronous input pins and raises a request when any pin that software has enabled moves away from a stored reference level. It catches both rising and falling transitions. The comparison is purely combinational, between the live pins and a latched reference. A wake output therefore follows a qualifying change even when the system clock is gated off for sleep. While the clock runs, the raw mismatch passes through a two-flop synchronizer and sets a sticky interrupt flag. Software clears that flag by writing a one.

Software reaches the unit through a small single-cycle register port. Every per-pin control is split into 16-bit words: pins 0 to 15 sit in the low word and pins 16 to 20 in the high word. The controls are an interrupt enable per pin and a weak-pull-up enable per pin. Reading the pin level words returns the synchronized pin levels. The same read reloads the whole reference from those levels, which clears the mismatch.

The pull-up enables leave the block only as control outputs. Each one is forced off for any pin that an external signal marks as a digital output.

Top module: `chg_notify`

Address map: the address is 3 bits, `{group[1:0], word}`.
- Group 0 holds the interrupt enables, at address 0 (low word) and address 1 (high word).
- Group 1 holds the pull-up enables, at addresses 2 and 3.
- Group 2 holds the pin levels, at addresses 4 and 5. These words are read-only.
- Group 3 is the status word, at addresses 6 and 7. Bit 0 is the flag, and writing 1 to bit 0 clears it.

## Requirements
- R1: After reset, every enable word and the status word read 0, irq_o, wake_o and pu_en_o are 0, and the reference is all zeros.
- R2: A write to the low word (word bit 0) of a group stores pins 0..15 from wdata bits 15:0. A write to the high word stores pins 16..20 from wdata bits 4:0. Bits 15:5 of every high word read as 0.
- R3: wake_o is high whenever an enabled pin differs from its reference bit. It responds with no clock edge, including while the clock is stopped.
- R4: Both a 0-to-1 and a 1-to-0 change of an enabled pin relative to its reference raise wake_o.
- R5: When an enabled mismatch appears, irq_o (also status bit 0) is still 0 after the second rising clock edge and is 1 after the third.
- R6: The flag stays set after the mismatch is gone. Writing 0 to status bit 0 leaves it set. Writing 1 clears it once the mismatch has been gone for 3 cycles.
- R7: Reading address 4 returns synchronized pins 15:0, and reading address 5 returns pins 20:16 in bits 4:0. Either read reloads the reference from the synchronized pins at that clock edge, so wake_o falls.
- R8: pu_en_o[i] equals the stored pull-up enable of pin i AND NOT dig_out_i[i]. The stored pull-up enable value is unaffected.
- R9: A clear write that coincides with a still-present synchronized mismatch clears the flag at that edge, and the flag sets again on the next edge.
- R10: A pin whose interrupt enable is 0 never affects wake_o or the flag. Clearing an enable removes that pin's contribution immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, may be stopped for sleep |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 21 | Asynchronous external pin levels |
| dig_out_i | input | 21 | Per-pin marker that the pin is driven as a digital output |
| reg_wr_i | input | 1 | Single-cycle register write strobe |
| reg_rd_i | input | 1 | Single-cycle register read strobe |
| reg_addr_i | input | 3 | Register address {group, word} |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| pu_en_o | output | 21 | Gated weak-pull-up enables |
| wake_o | output | 1 | Combinational clock-free change indication |
| irq_o | output | 1 | Sticky synchronized interrupt flag |

## Verification
The assertions take three things for granted. Reset is asserted before the first clock edge. Read and write strobes are never given together. A flag clear written within three cycles of a reference reload may be undone by the synchronizer still holding the old mismatch. The stimulus keeps to these limits. It changes pins and strobes only in the low clock phase. It waits three cycles after every pin change before a level read. It spaces each reload and the following clear by at least three cycles. It also stops and restarts the gated clock only while the clock is low, so the block never sees a shortened pulse.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    GRP_IEN  = 2'd0,
    GRP_PU   = 2'd1,
    GRP_PIN  = 2'd2,
    GRP_STAT = 2'd3
  } chg_grp_e;

  function automatic int words_for(input int n, input int w);
    return (n + w - 1) / w;
  endfunction

  function automatic int idx_w_for(input int n, input int w);
    return (words_for(n, w) > 1) ? $clog2(words_for(n, w)) : 1;
  endfunction

  function automatic int addr_w_for(input int n, input int w);
    return 2 + idx_w_for(n, w);
  endfunction
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/chg_detect.sv
module chg_detect #(
  parameter int N = 21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] pins_sync_i,
  input  logic [N-1:0] ien_i,
  input  logic         load_i,
  output logic [N-1:0] mismatch_o
);
  logic [N-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= '0;
    else if (load_i) ref_q <= pins_sync_i;
  end

  // clock-free compare path, valid while clk_i is stopped
  assign mismatch_o = (pins_i ^ ref_q) & ien_i;

  a_r7_reload_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ref_q == $past(pins_sync_i)));
endmodule

// File: rtl/chg_regs.sv
module chg_regs
  import chg_pkg::*;
#(
  parameter int N      = 21,
  parameter int REG_W  = 16,
  parameter int ADDR_W = addr_w_for(N, REG_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [N-1:0]      pins_sync_i,
  input  logic              flag_i,
  output logic [N-1:0]      ien_o,
  output logic [N-1:0]      pu_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              load_o,
  output logic              clr_o
);
  localparam int N_WORDS = words_for(N, REG_W);
  localparam int PAD_W   = N_WORDS * REG_W;
  localparam int IDX_W   = idx_w_for(N, REG_W);

  chg_grp_e         grp;
  logic [IDX_W-1:0] idx;
  logic [N_WORDS-1:0] idx_hit;
  logic [PAD_W-1:0] ien_q, pu_q, pin_pad;
  logic [REG_W-1:0] ien_w, pu_w, pin_w;

  assign grp = chg_grp_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx = addr_i[IDX_W-1:0];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_hit
    assign idx_hit[w] = (int'(idx) == w);
  end

  for (genvar b = 0; b < PAD_W; b++) begin : g_bit
    if (b < N) begin : g_used
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ien_q[b] <= 1'b0;
          pu_q[b]  <= 1'b0;
        end else if (wr_i && idx_hit[b / REG_W]) begin
          if (grp == GRP_IEN) ien_q[b] <= wdata_i[b % REG_W];
          if (grp == GRP_PU)  pu_q[b]  <= wdata_i[b % REG_W];
        end
      end
    end else begin : g_pad
      assign ien_q[b] = 1'b0;
      assign pu_q[b]  = 1'b0;
    end
  end

  always_comb begin
    pin_pad = '0;
    pin_pad[N-1:0] = pins_sync_i;
  end

  always_comb begin
    ien_w = '0;
    pu_w  = '0;
    pin_w = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (idx_hit[w]) begin
        ien_w = ien_q[w*REG_W +: REG_W];
        pu_w  = pu_q[w*REG_W +: REG_W];
        pin_w = pin_pad[w*REG_W +: REG_W];
      end
    end
  end

  always_comb begin
    unique case (grp)
      GRP_IEN: rdata_o = ien_w;
      GRP_PU:  rdata_o = pu_w;
      GRP_PIN: rdata_o = pin_w;
      default: rdata_o = {{(REG_W-1){1'b0}}, flag_i};
    endcase
  end

  assign ien_o  = ien_q[N-1:0];
  assign pu_o   = pu_q[N-1:0];
  assign load_o = rd_i && (grp == GRP_PIN);
  assign clr_o  = wr_i && (grp == GRP_STAT) && wdata_i[0];

  if (N % REG_W != 0) begin : g_hi_chk
    localparam int TOP_USED = N - (N_WORDS - 1) * REG_W;
    a_r2_hi_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp != GRP_STAT && idx_hit[N_WORDS-1]) |-> (rdata_o[REG_W-1:TOP_USED] == '0));
  end
endmodule

// File: rtl/chg_notify.sv
module chg_notify
  import chg_pkg::*;
#(
  parameter int N_PINS = 21,
  parameter int REG_W  = 16
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [N_PINS-1:0]                     pins_i,
  input  logic [N_PINS-1:0]                     dig_out_i,
  input  logic                                  reg_wr_i,
  input  logic                                  reg_rd_i,
  input  logic [addr_w_for(N_PINS, REG_W)-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]                      reg_wdata_i,
  output logic [REG_W-1:0]                      reg_rdata_o,
  output logic [N_PINS-1:0]                     pu_en_o,
  output logic                                  wake_o,
  output logic                                  irq_o
);
  localparam int ADDR_W = addr_w_for(N_PINS, REG_W);

  logic [N_PINS-1:0] pins_s, ien, pu, mism;
  logic load, clr, mism_s, flag_q;

  chg_sync #(.W(N_PINS)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(pins_s)
  );

  chg_regs #(.N(N_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .pins_sync_i(pins_s),
    .flag_i(flag_q), .ien_o(ien), .pu_o(pu), .rdata_o(reg_rdata_o),
    .load_o(load), .clr_o(clr)
  );

  chg_detect #(.N(N_PINS)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .pins_sync_i(pins_s),
    .ien_i(ien), .load_i(load), .mismatch_o(mism)
  );

  assign wake_o = |mism;

  chg_sync #(.W(1)) u_mism_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wake_o), .q_o(mism_s)
  );

  // clear has priority; a persisting mismatch re-sets on the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (clr)    flag_q <= 1'b0;
    else if (mism_s) flag_q <= 1'b1;
  end

  assign irq_o   = flag_q;
  assign pu_en_o = pu & ~dig_out_i;

  a_r5_flag_from_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(mism_s));
  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr) |=> flag_q);
  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !flag_q);
endmodule

// File: tb/chg_notify_test.sv
module chg_notify_test;
  logic clk_base = 1'b0;
  logic clk_run  = 1'b1;
  logic clk;
  logic rst_ni;
  logic [20:0] pins_i, dig_out_i, pu_en_o;
  logic reg_wr_i, reg_rd_i, wake_o, irq_o;
  logic [2:0]  reg_addr_i;
  logic [15:0] reg_wdata_i, reg_rdata_o, d;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_base = ~clk_base;
  assign clk = clk_base & clk_run;

  chg_notify uut (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins_i), .dig_out_i(dig_out_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pu_en_o(pu_en_o),
    .wake_o(wake_o), .irq_o(irq_o)
  );

  // {ien, pins, expected wake} against an all-zero reference
  localparam logic [42:0] VEC [0:7] = '{
    {21'h000000, 21'h1FFFFF, 1'b0},
    {21'h000001, 21'h000001, 1'b1},
    {21'h100000, 21'h080000, 1'b0},
    {21'h100000, 21'h100000, 1'b1},
    {21'h018000, 21'h010000, 1'b1},
    {21'h1FFFFF, 21'h000000, 1'b0},
    {21'h0AAAAA, 21'h155555, 1'b0},
    {21'h0AAAAA, 21'h000002, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #2 v = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  task automatic set_ien(input logic [20:0] v);
    wr(3'd0, v[15:0]);
    wr(3'd1, {11'b0, v[20:16]});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; pins_i = '0; dig_out_i = '0;
    reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    repeat (3) @(negedge clk_base);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_o, 0);
    chk("R1 pu_en", pu_en_o, 0);
    rd(3'd0, d); chk("R1 ien lo", d, 0);
    rd(3'd1, d); chk("R1 ien hi", d, 0);
    rd(3'd3, d); chk("R1 pu hi", d, 0);
    rd(3'd6, d); chk("R1 status", d, 0);

    // R3 / R10 table walk
    for (int i = 0; i < 8; i++) begin
      set_ien(VEC[i][42:22]);
      pins_i = VEC[i][21:1];
      #1 chk($sformatf("R3 R10 vec%0d wake", i), wake_o, VEC[i][0]);
    end

    // R7 pin read and reload
    pins_i = 21'h1A5A5A;
    wait_n(3);
    rd(3'd4, d); chk("R7 pins lo", d, 16'h5A5A);
    rd(3'd5, d); chk("R7 pins hi", d, 16'h001A);
    set_ien(21'h1FFFFF);
    chk("R7 wake after reload", wake_o, 0);
    wait_n(3);
    wr(3'd6, 16'h0001);
    chk("R6 clear", irq_o, 0);
    wait_n(4);
    chk("R6 stays clear", irq_o, 0);

    // R4 falling change, R5 latency
    pins_i = 21'h1A5A52;
    #1 chk("R4 falling wake", wake_o, 1);
    wait_n(2);
    chk("R5 irq after 2 edges", irq_o, 0);
    wait_n(1);
    chk("R5 irq after 3 edges", irq_o, 1);
    rd(3'd6, d); chk("R5 status bit", d, 16'h0001);

    // R9 clear against live mismatch
    wr(3'd6, 16'h0001);
    chk("R9 cleared at edge", irq_o, 0);
    wait_n(1);
    chk("R9 set again", irq_o, 1);

    // R6 sticky after mismatch removed
    rd(3'd4, d);
    chk("R7 wake drop", wake_o, 0);
    wait_n(3);
    chk("R6 sticky", irq_o, 1);
    wr(3'd6, 16'h0000);
    chk("R6 write zero", irq_o, 1);
    wr(3'd6, 16'h0001);
    chk("R6 w1c", irq_o, 0);
    wait_n(3);
    chk("R6 no reset", irq_o, 0);

    // R10 disabling an enable drops its contribution
    pins_i = 21'h0A5A52;
    #1 chk("R10 enabled bit20", wake_o, 1);
    set_ien(21'h0FFFFF);
    chk("R10 masked bit20", wake_o, 0);
    rd(3'd5, d);
    wait_n(3);
    wr(3'd6, 16'h0001);
    set_ien(21'h1FFFFF);
    chk("R10 reloaded, no wake", wake_o, 0);
    wait_n(3);
    chk("R10 flag clear", irq_o, 0);

    // R3 with clock stopped
    clk_run = 1'b0;
    #40 pins_i = 21'h0B5A52;
    #5 chk("R3 wake no clock", wake_o, 1);
    #400 chk("R3 irq held no clock", irq_o, 0);
    @(negedge clk_base);
    clk_run = 1'b1;
    wait_n(3);
    chk("R3 irq after restart", irq_o, 1);

    // R8 pull-up gating, R2 high word
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'hFFFF);
    dig_out_i = 21'h00F0F0;
    #1 chk("R8 pu gated", pu_en_o, 21'h1F0F0F);
    rd(3'd3, d); chk("R2 pu hi zero-fill", d, 16'h001F);
    rd(3'd2, d); chk("R8 pu stored", d, 16'hFFFF);
    dig_out_i = 21'h1FFFFF;
    #1 chk("R8 all outputs", pu_en_o, 0);
    wr(3'd1, 16'hFFE0);
    rd(3'd1, d); chk("R2 ien hi", d, 16'h0000);
    wr(3'd0, 16'h8001);
    rd(3'd0, d); chk("R2 ien lo", d, 16'h8001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule